// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the register front end that runs one analog-to-digital conversion at a time for a ten-input acquisition card. Software writes a 16-bit control word. The word names the input to convert and carries a one-hot mask of the inputs that may be converted. It can also ask for a settling wait before sampling. The block checks the request, holds the channel select toward the converter, optionally waits, and then issues a single start strobe.

When the converter returns its done pulse, the block stores the raw 16-bit result and raises a sticky completion flag in the status register. If the matching interrupt-enable bit is set, the flag also drives the interrupt line. Software clears the flag by writing a one to it. The result is kept in offset-binary form, so flipping its top bit gives the two's-complement value. Inputs 0 to 7 are the differential inputs, input 8 is the positive reference and input 9 is the zero-volt reference.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control, enable, status and data registers all read 0, and irq and conv_start are low.
- R2: A control write with bit 0 set to an idle block is accepted when bits 4:1 select a channel in 0..9 whose bit (5 + channel) is set. Without the delay bit, conv_start then goes high for exactly one cycle, the cycle after the write, with conv_chan equal to that channel.
- R3: If the accepted control word also has bit 15 set, conv_start pulses SETTLE_CYCLES cycles after the cycle it would have pulsed without the delay.
- R4: Status bit 0 (busy) reads 1 from the cycle after an accepted start until the conversion completes. A start write arriving while busy produces no start strobe.
- R5: A start request is ignored when its channel's mask bit is clear or when the channel select is 10 or more. No strobe is issued, busy stays 0 and the done flag is not set.
- R6: A conv_done pulse while a conversion is outstanding stores conv_result in the data register and sets status bit 2 (done) on the next cycle.
- R7: Writing the status register with bit 2 set clears the done flag. Writing it with bit 2 clear leaves the flag unchanged. A completion in the same cycle wins over the clear.
- R8: irq is high exactly while the done flag is set and bit 2 of the interrupt-enable register is 1.
- R9: The data register keeps the last stored result until the next completion. Reads have no side effects, and a conv_done pulse with no conversion outstanding changes neither the data nor the done flag.
- R10: Register select (bus_addr) encodings are 0 control, 1 interrupt enable, 2 status and 3 data. The control register reads back the last word written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| conv_chan | output | 4 | Channel select held toward the converter |
| conv_start | output | 1 | One-cycle converter start strobe |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 16 | Raw offset-binary result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked by the assertions on every clock:
- the start strobe lasts a single cycle and only occurs while busy;
- a completion always sets the done flag;
- a one-write to the flag clears it unless a completion coincides;
- an enabled completion raises irq;
- the stored result moves only on a completion;
- a start to a masked-off channel never leaves the block busy.

The exact strobe cycle with and without the settling wait, and the suppression of a second start while busy, can only be shown by the bench's scenarios. The same holds for the held result across reads and stray done pulses, and for the channel values reaching the converter. The bench's scoreboard predicts each strobe's cycle and channel from the requirements.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_COUNT = 10;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CHSEL_W  = 4;
  localparam int unsigned DONE_BIT = 2;
  localparam int unsigned BUSY_BIT = 0;
  localparam int unsigned IEN_BIT  = 2;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [CHSEL_W-1:0] chan_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_IEN  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_FIRE   = 2'd2,
    SQ_WAIT   = 2'd3
  } seq_state_e;

  // control word, MSB first: settle request, enable mask, channel, go
  typedef struct packed {
    logic                settle;
    logic [CH_COUNT-1:0] en_mask;
    chan_t               chan;
    logic                go;
  } ctrl_word_t;

  // true when the selected channel exists and its mask bit is set
  function automatic logic chan_armed(ctrl_word_t w);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < CH_COUNT; i++) begin
      if (w.chan == chan_t'(i) && w.en_mask[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic word_t status_word(logic done, logic busy);
    word_t v;
    v = '0;
    v[DONE_BIT] = done;
    v[BUSY_BIT] = busy;
    return v;
  endfunction

  function automatic word_t ien_word(logic en);
    word_t v;
    v = '0;
    v[IEN_BIT] = en;
    return v;
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ctrl,
  input  logic     wr_ien,
  input  logic     wr_stat,
  input  word_t    wdata,
  input  logic     capture,
  input  word_t    result_in,
  input  logic     busy,
  input  reg_sel_e rd_sel,
  output word_t    rdata,
  output logic     ien_done,
  output logic     done_flag,
  output word_t    result_hold
);
  word_t ctrl_q;
  logic  clear_req;

  assign clear_req = wr_stat && wdata[DONE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      ien_done    <= 1'b0;
      done_flag   <= 1'b0;
      result_hold <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_ien)  ien_done <= wdata[IEN_BIT];
      if (capture) begin
        done_flag   <= 1'b1;
        result_hold <= result_in;
      end else if (clear_req) begin
        done_flag <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      REG_CTRL: rdata = ctrl_q;
      REG_IEN:  rdata = ien_word(ien_done);
      REG_STAT: rdata = status_word(done_flag, busy);
      REG_DATA: rdata = result_hold;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  want_settle,
  input  chan_t chan_in,
  input  logic  conv_done,
  output logic  conv_start,
  output chan_t conv_chan,
  output logic  busy,
  output logic  capture
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  chan_t            chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          chan_q  <= chan_in;
          cnt_q   <= CNT_LOAD;
          state_q <= want_settle ? SQ_SETTLE : SQ_FIRE;
        end
        SQ_SETTLE: begin
          if (cnt_q == '0) state_q <= SQ_FIRE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SQ_FIRE: state_q <= SQ_WAIT;
        SQ_WAIT: if (conv_done) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_start = (state_q == SQ_FIRE);
  assign conv_chan  = chan_q;
  assign busy       = (state_q != SQ_IDLE);
  assign capture    = (state_q == SQ_WAIT) && conv_done;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [3:0]  conv_chan,
  output logic        conv_start,
  input  logic        conv_done,
  input  logic [15:0] conv_result,
  output logic        irq
);
  reg_sel_e   sel_w;
  ctrl_word_t req_w;
  logic       wr_ctrl, wr_ien, wr_stat;
  logic       start_accept, busy_w, capture_w;
  logic       done_q, ien_q;
  word_t      result_q;

  assign sel_w   = reg_sel_e'(bus_addr);
  assign req_w   = ctrl_word_t'(bus_wdata);
  assign wr_ctrl = bus_wr_en && (sel_w == REG_CTRL);
  assign wr_ien  = bus_wr_en && (sel_w == REG_IEN);
  assign wr_stat = bus_wr_en && (sel_w == REG_STAT);

  assign start_accept = wr_ctrl && req_w.go && chan_armed(req_w) && !busy_w;

  adc_seq_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (start_accept),
    .want_settle(req_w.settle),
    .chan_in    (req_w.chan),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy_w),
    .capture    (capture_w)
  );

  adc_seq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_ien     (wr_ien),
    .wr_stat    (wr_stat),
    .wdata      (bus_wdata),
    .capture    (capture_w),
    .result_in  (conv_result),
    .busy       (busy_w),
    .rd_sel     (sel_w),
    .rdata      (bus_rdata),
    .ien_done   (ien_q),
    .done_flag  (done_q),
    .result_hold(result_q)
  );

  assign irq = done_q && ien_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        conv_start,
  input logic        irq,
  input logic        busy_w,
  input logic        capture_w,
  input logic        done_q,
  input logic        ien_q,
  input logic [15:0] result_q
);
  logic [3:0]  req_ch;
  logic [15:0] shifted;
  logic        req_ok;

  assign req_ch  = bus_wdata[4:1];
  assign shifted = bus_wdata >> (5 + req_ch);
  assign req_ok  = (req_ch < 4'd10) && shifted[0];

  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_start_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_w);

  assert_masked_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 2'd0 && bus_wdata[0] && !req_ok && !busy_w) |=> !busy_w);

  assert_capture_sets_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> done_q);

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 2'd2 && bus_wdata[2] && !capture_w) |=> !done_q);

  assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_w && ien_q && !(bus_wr_en && bus_addr == 2'd1)) |=> irq);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_w |=> $stable(result_q));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .conv_start(conv_start),
  .irq       (irq),
  .busy_w    (busy_w),
  .capture_w (capture_w),
  .done_q    (done_q),
  .ien_q     (ien_q),
  .result_q  (result_q)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int TB_SETTLE = 16;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [3:0]  conv_chan;
  logic        conv_start;
  logic        conv_done = 1'b0;
  logic [15:0] conv_result = 16'd0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_wr_cyc = 0;
  bit finished = 0;

  typedef struct { logic [3:0] ch; int at; } exp_t;
  exp_t exp_q[$];

  logic [15:0] model_result = 16'd0;
  int          lat_cnt = 0;
  int          seq_no = 0;
  logic [15:0] pend = 16'd0;
  logic        stray_req = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl #(.SETTLE_CYCLES(TB_SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .irq(irq)
  );

  function automatic logic [15:0] stub_value(logic [3:0] ch, int n);
    return 16'h8000 ^ {ch, 12'(n * 211 + 7)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // converter stub: fixed latency after each strobe, optional stray pulse
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (stray_req) begin
      conv_done   <= 1'b1;
      conv_result <= 16'hDEAD;
    end
    if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        conv_done    <= 1'b1;
        conv_result  <= pend;
        model_result <= pend;
      end
    end else if (rst_n && conv_start) begin
      lat_cnt <= LAT;
      pend    <= stub_value(conv_chan, seq_no);
      seq_no  <= seq_no + 1;
    end
  end

  // scoreboard monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4 unexpected strobe actual=1 expected=0 chan=%0d", conv_chan);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R2 strobe channel", 32'(conv_chan), 32'(e.ch));
        check("R2/R3 strobe cycle", 32'(cyc), 32'(e.at));
      end
    end
  end

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 last_wr_cyc = cyc;
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic start_conv(logic [3:0] ch, logic [9:0] mask, logic dly, bit expect_ok);
    exp_t e;
    bus_write(2'd0, {dly, mask, ch, 1'b1});
    if (expect_ok) begin
      e.ch = ch;
      e.at = last_wr_cyc + (dly ? TB_SETTLE : 0);
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 500; i++) begin
      bus_read(2'd2, s);
      if (!s[0]) return;
    end
    check("R4 busy never cleared", 32'd1, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] held;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd0, rd); check("R1 ctrl", 32'(rd), 32'h0);
    bus_read(2'd1, rd); check("R1 ien", 32'(rd), 32'h0);
    bus_read(2'd2, rd); check("R1 status", 32'(rd), 32'h0);
    bus_read(2'd3, rd); check("R1 data", 32'(rd), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 conv_start", 32'(conv_start), 32'h0);

    // R10 control readback, go bit clear so nothing starts
    bus_write(2'd0, 16'h1234);
    bus_read(2'd0, rd); check("R10 ctrl readback", 32'(rd), 32'h1234);

    // R2 plain conversion on channel 3
    start_conv(4'd3, 10'h008, 1'b0, 1);
    bus_read(2'd2, rd); check("R4 busy after start", 32'(rd[0]), 32'h1);
    wait_idle();
    bus_read(2'd2, rd); check("R6 done flag", 32'(rd), 32'h0004);
    bus_read(2'd3, rd); check("R6 data", 32'(rd), 32'(stub_value(4'd3, 0)));
    check("R8 irq masked", 32'(irq), 32'h0);

    // R7 write-zero keeps, R8 enable, R7 write-one clears
    bus_write(2'd2, 16'h0000);
    bus_read(2'd2, rd); check("R7 zero write keeps flag", 32'(rd), 32'h0004);
    bus_write(2'd1, 16'h0004);
    bus_read(2'd1, rd); check("R10 ien readback", 32'(rd), 32'h0004);
    @(negedge clk); check("R8 irq enabled", 32'(irq), 32'h1);
    bus_write(2'd2, 16'h0004);
    bus_read(2'd2, rd); check("R7 one write clears", 32'(rd), 32'h0);
    check("R8 irq cleared", 32'(irq), 32'h0);

    // R3 settle delay on channel 8, R4 second start while busy ignored
    start_conv(4'd8, 10'h3FF, 1'b1, 1);
    start_conv(4'd1, 10'h3FF, 1'b0, 0);
    bus_read(2'd2, rd); check("R4 busy during settle", 32'(rd[0]), 32'h1);
    wait_idle();
    bus_read(2'd3, rd); check("R3 data after delay", 32'(rd), 32'(stub_value(4'd8, 1)));
    check("R8 irq after completion", 32'(irq), 32'h1);
    bus_write(2'd2, 16'h0004);

    // R5 masked channel and out-of-range channel
    start_conv(4'd5, 10'h010, 1'b0, 0);
    repeat (3) @(negedge clk);
    bus_read(2'd2, rd); check("R5 masked ignored", 32'(rd), 32'h0);
    start_conv(4'd12, 10'h3FF, 1'b0, 0);
    repeat (3) @(negedge clk);
    bus_read(2'd2, rd); check("R5 channel 12 ignored", 32'(rd), 32'h0);

    // R9 data held across reads and a stray done pulse
    bus_read(2'd3, held);
    bus_read(2'd3, rd); check("R9 read no side effect", 32'(rd), 32'(held));
    @(posedge clk); #1 stray_req = 1'b1;
    @(posedge clk); #1 stray_req = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(2'd3, rd); check("R9 stray done ignored data", 32'(rd), 32'(stub_value(4'd8, 1)));
    bus_read(2'd2, rd); check("R9 stray done no flag", 32'(rd), 32'h0);

    // R2 top channel 9
    start_conv(4'd9, 10'h200, 1'b0, 1);
    wait_idle();
    bus_read(2'd3, rd); check("R2 channel 9 data", 32'(rd), 32'(stub_value(4'd9, 2)));
    check("R6 model agrees", 32'(rd), 32'(model_result));

    repeat (4) @(negedge clk);
    check("R4 all strobes matched", 32'(exp_q.size()), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule